// File: doc/BRIEF.md
# Power-Management Function I/O Window Decoder

This block holds the configuration registers of a power-management PCI function and turns two of them into I/O address windows. One window is 128 bytes of power-management registers. The other is a 16-byte SMBus controller window. Software reaches the registers through a dword-indexed configuration port that has per-byte lane enables. The block applies a write mask and fixed bits to each register, merges partial writes into the stored dword, and returns the stored value on a combinational read path.

An I/O address input is compared against both windows. For each window the block gives a hit flag and the offset of the address inside that window. The window bases and enables are not taken directly from the registers. A two-state controller copies them into decode registers one cycle after a configuration write commits. The states are `WIN_IDLE` (decode registers hold their value) and `WIN_REFRESH` (decode registers reload from the configuration registers). The controller has three transitions:
- A committed write moves `WIN_IDLE` to `WIN_REFRESH`.
- A cycle in `WIN_REFRESH` with no write returns to `WIN_IDLE`.
- A further write while in `WIN_REFRESH` keeps the controller in `WIN_REFRESH`.

Top module: `pm_iowin_decoder`

## Requirements
- R1: After reset, the registers read as follows: index 0x01 (command word) reads 0, index 0x12 (byte offset 0x48) reads 0x00000001, index 0x24 (byte offset 0x90) reads 0x00000001, index 0x34 reads 0, and indices 0x10 and 0x20 read 0. Both hit outputs are low.
- R2: On a write, each byte lane k with `cfg_be[k]` set replaces bits 8k+7:8k of the addressed dword, and the other lanes keep their stored value. Index 0x10 and index 0x12 store all 32 bits. Index 0x01 stores only its low 16 bits and reads 0 in the upper 16 bits. Index 0x20 stores only lane 0.
- R3: A write to index 0x24 with any lane enabled stores the merged value ANDed with 0x0000fff0, and then forces bit 0 to 1.
- R4: Lane 2 of index 0x34 is byte offset 0xd2. A write with `cfg_be[2]` set stores only `cfg_wdata[19:16]`, and the upper nibble of that byte reads 0. A write without lane 2 leaves the byte unchanged. The other bytes of index 0x34 read 0.
- R5: The power-management window has base (dword 0x10 AND 0xffc0) and is enabled by bit 0 of index 0x20. While enabled, it hits for addresses in [base, base+128), and `pm_offset` equals the address minus the base. The window does not wrap past 0xffff.
- R6: The SMBus window has base (dword 0x24 AND 0xfff0) and is enabled by bit 0 of the byte at offset 0xd2. While enabled, it hits for addresses in [base, base+16), and `smb_offset` equals the address minus the base.
- R7: A write committed at clock edge N is visible on `cfg_rdata` after edge N. The hit decode still shows the old window between edges N and N+1, and shows the new window after edge N+1.
- R8: Indices other than 0x01, 0x10, 0x12, 0x20, 0x24 and 0x34 read 0, and writes to them change no register and no window.
- R9: When writes are committed on consecutive edges, the controller stays in `WIN_REFRESH`. The decode after the edge that follows the last write reflects that last write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe, committed at the clock edge |
| cfg_idx | input | 6 | Dword index (byte offset divided by 4) for write and read |
| cfg_be | input | 4 | Byte-lane enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the indexed dword |
| io_addr | input | 16 | I/O address to decode |
| pm_hit | output | 1 | Address falls inside the enabled power-management window |
| pm_offset | output | 7 | Offset of the address inside the power-management window |
| smb_hit | output | 1 | Address falls inside the enabled SMBus window |
| smb_offset | output | 4 | Offset of the address inside the SMBus window |

## Verification
A configuration write and an I/O decode can happen in the same cycle. The bench provokes this by holding an address inside a window it is about to enable. It then checks that the hit stays at the old value through the commit cycle and changes only one edge later. Both windows can also claim one address in the same cycle. The bench places the SMBus base inside the power-management window and checks that both hits and both offsets agree with arithmetic on the programmed bases.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
    localparam int CFG_IW = 6;
    localparam int IO_AW  = 16;

    localparam logic [CFG_IW-1:0] IDX_CMD     = 6'h01;
    localparam logic [CFG_IW-1:0] IDX_PMBASE  = 6'h10;
    localparam logic [CFG_IW-1:0] IDX_MISC    = 6'h12;
    localparam logic [CFG_IW-1:0] IDX_PMCTL   = 6'h20;
    localparam logic [CFG_IW-1:0] IDX_SMBBASE = 6'h24;
    localparam logic [CFG_IW-1:0] IDX_SMBCTL  = 6'h34;

    localparam logic [31:0] PM_BASE_MASK  = 32'h0000_ffc0;
    localparam logic [31:0] SMB_BASE_MASK = 32'h0000_fff0;
    localparam logic [31:0] MISC_RESET    = 32'h0000_0001;
    localparam logic [31:0] SMBBASE_RESET = 32'h0000_0001;

    typedef enum logic [0:0] {
        WIN_IDLE    = 1'b0,
        WIN_REFRESH = 1'b1
    } win_state_e;

    typedef struct packed {
        logic             en;
        logic [IO_AW-1:0] base;
    } win_cfg_t;
endpackage

// File: rtl/pmw_cfg_regs.sv
module pmw_cfg_regs
    import pmw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CFG_IW-1:0] idx,
    input  logic [3:0]        be,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output win_cfg_t          pm_cfg,
    output win_cfg_t          smb_cfg
);
    logic [15:0] cmd_q;
    logic [31:0] pmbase_q;
    logic [31:0] misc_q;
    logic [7:0]  pmctl_q;
    logic [31:0] smbbase_q;
    logic [3:0]  smbctl_q;

    function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                               input logic [31:0] new_v,
                                               input logic [3:0]  lanes);
        logic [31:0] r;
        r = old_v;
        for (int k = 0; k < 4; k++) begin
            if (lanes[k]) r[8*k +: 8] = new_v[8*k +: 8];
        end
        return r;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            pmbase_q  <= '0;
            misc_q    <= MISC_RESET;
            pmctl_q   <= '0;
            smbbase_q <= SMBBASE_RESET;
            smbctl_q  <= '0;
        end else if (wr_en) begin
            case (idx)
                IDX_CMD:    cmd_q    <= lane_merge({16'h0, cmd_q}, wdata, be) >> 0 == 32'h0 ? 16'h0
                                        : lane_merge({16'h0, cmd_q}, wdata, be) & 32'h0000_ffff;
                IDX_PMBASE: pmbase_q <= lane_merge(pmbase_q, wdata, be);
                IDX_MISC:   misc_q   <= lane_merge(misc_q, wdata, be);
                IDX_PMCTL:  if (be[0]) pmctl_q <= wdata[7:0];
                IDX_SMBBASE: if (|be)
                    smbbase_q <= (lane_merge(smbbase_q, wdata, be) & SMB_BASE_MASK) | 32'h1;
                IDX_SMBCTL: if (be[2]) smbctl_q <= wdata[19:16];
                default: ;
            endcase
        end
    end

    always_comb begin
        case (idx)
            IDX_CMD:     rdata = {16'h0, cmd_q};
            IDX_PMBASE:  rdata = pmbase_q;
            IDX_MISC:    rdata = misc_q;
            IDX_PMCTL:   rdata = {24'h0, pmctl_q};
            IDX_SMBBASE: rdata = smbbase_q;
            IDX_SMBCTL:  rdata = {12'h0, smbctl_q, 16'h0};
            default:     rdata = '0;
        endcase
    end

    always_comb begin
        pm_cfg.en    = pmctl_q[0];
        pm_cfg.base  = pmbase_q[IO_AW-1:0] & PM_BASE_MASK[IO_AW-1:0];
        smb_cfg.en   = smbctl_q[0];
        smb_cfg.base = smbbase_q[IO_AW-1:0] & SMB_BASE_MASK[IO_AW-1:0];
    end
endmodule

// File: rtl/pmw_win_ctrl.sv
module pmw_win_ctrl
    import pmw_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  win_cfg_t pm_src,
    input  win_cfg_t smb_src,
    output win_cfg_t pm_win,
    output win_cfg_t smb_win,
    output logic     refresh
);
    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_IDLE:    if (wr_en) state_d = WIN_REFRESH;
            WIN_REFRESH: state_d = wr_en ? WIN_REFRESH : WIN_IDLE;
            default:     state_d = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WIN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        refresh = (state_q == WIN_REFRESH);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pm_win  <= '0;
            smb_win <= '0;
        end else if (refresh) begin
            pm_win  <= pm_src;
            smb_win <= smb_src;
        end
    end
endmodule

// File: rtl/pmw_win_match.sv
module pmw_win_match #(
    parameter int AW      = 16,
    parameter int SIZE_LG = 7
) (
    input  logic               en,
    input  logic [AW-1:0]      base,
    input  logic [AW-1:0]      addr,
    output logic               hit,
    output logic [SIZE_LG-1:0] offset
);
    localparam logic [AW:0] SPAN = (AW+1)'(1) << SIZE_LG;

    logic [AW:0] limit;

    always_comb begin
        limit  = {1'b0, base} + SPAN;
        hit    = en && (addr >= base) && ({1'b0, addr} < limit);
        offset = addr[SIZE_LG-1:0] - base[SIZE_LG-1:0];
    end
endmodule

// File: rtl/pm_iowin_decoder.sv
module pm_iowin_decoder
    import pmw_pkg::*;
#(
    parameter int PM_SPAN_LG  = 7,
    parameter int SMB_SPAN_LG = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [CFG_IW-1:0]      cfg_idx,
    input  logic [3:0]             cfg_be,
    input  logic [31:0]            cfg_wdata,
    output logic [31:0]            cfg_rdata,
    input  logic [IO_AW-1:0]       io_addr,
    output logic                   pm_hit,
    output logic [PM_SPAN_LG-1:0]  pm_offset,
    output logic                   smb_hit,
    output logic [SMB_SPAN_LG-1:0] smb_offset
);
    win_cfg_t pm_src, smb_src, pm_win, smb_win;
    logic     refresh;

    pmw_cfg_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .idx    (cfg_idx),
        .be     (cfg_be),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .pm_cfg (pm_src),
        .smb_cfg(smb_src)
    );

    pmw_win_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_wr),
        .pm_src (pm_src),
        .smb_src(smb_src),
        .pm_win (pm_win),
        .smb_win(smb_win),
        .refresh(refresh)
    );

    pmw_win_match #(.AW(IO_AW), .SIZE_LG(PM_SPAN_LG)) u_pm_match (
        .en    (pm_win.en),
        .base  (pm_win.base),
        .addr  (io_addr),
        .hit   (pm_hit),
        .offset(pm_offset)
    );

    pmw_win_match #(.AW(IO_AW), .SIZE_LG(SMB_SPAN_LG)) u_smb_match (
        .en    (smb_win.en),
        .base  (smb_win.base),
        .addr  (io_addr),
        .hit   (smb_hit),
        .offset(smb_offset)
    );
endmodule

// File: rtl/pmw_checker.sv
module pmw_checker
    import pmw_pkg::*;
#(
    parameter int PM_SPAN_LG  = 7,
    parameter int SMB_SPAN_LG = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_wr,
    input logic [CFG_IW-1:0]      cfg_idx,
    input logic [31:0]            cfg_rdata,
    input logic [IO_AW-1:0]       io_addr,
    input logic                   pm_hit,
    input logic [PM_SPAN_LG-1:0]  pm_offset,
    input logic                   smb_hit,
    input logic [SMB_SPAN_LG-1:0] smb_offset,
    input logic                   refresh
);
    assert_smbbase_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_SMBBASE) |-> (cfg_rdata[3:0] == 4'h1 && cfg_rdata[31:16] == 16'h0));

    assert_smbctl_nibble_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_idx == IDX_SMBCTL) |-> (cfg_rdata[31:20] == 12'h0 && cfg_rdata[15:0] == 16'h0));

    assert_pm_offset_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pm_hit |-> (pm_offset[5:0] == io_addr[5:0]));

    assert_smb_offset_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
        smb_hit |-> (smb_offset == io_addr[SMB_SPAN_LG-1:0]));

    assert_decode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(cfg_wr, 1) && !$past(cfg_wr, 2) && $stable(io_addr))
            |-> ($stable(pm_hit) && $stable(smb_hit)));

    assert_refresh_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> refresh);

    assert_refresh_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh |-> $past(cfg_wr));
endmodule

bind pm_iowin_decoder pmw_checker #(
    .PM_SPAN_LG (PM_SPAN_LG),
    .SMB_SPAN_LG(SMB_SPAN_LG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_idx   (cfg_idx),
    .cfg_rdata (cfg_rdata),
    .io_addr   (io_addr),
    .pm_hit    (pm_hit),
    .pm_offset (pm_offset),
    .smb_hit   (smb_hit),
    .smb_offset(smb_offset),
    .refresh   (refresh)
);

// File: tb/sim_pm_iowin_decoder.sv
module sim_pm_iowin_decoder;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        pm_hit, smb_hit;
    logic [6:0]  pm_offset;
    logic [3:0]  smb_offset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_cmd = 16'h0;
    logic [31:0] m_pmb = 32'h0, m_misc = 32'h1, m_smbb = 32'h1;
    logic [7:0]  m_pmctl = 8'h0, m_smbctl = 8'h0;

    pm_iowin_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .pm_hit(pm_hit), .pm_offset(pm_offset),
        .smb_hit(smb_hit), .smb_offset(smb_offset)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                          input logic [3:0] b);
        logic [31:0] r = o;
        for (int k = 0; k < 4; k++) if (b[k]) r[8*k +: 8] = n[8*k +: 8];
        return r;
    endfunction

    task automatic model_write(input logic [5:0] i, input logic [3:0] b, input logic [31:0] d);
        case (i)
            6'h01: m_cmd = merge({16'h0, m_cmd}, d, b) & 32'hffff;
            6'h10: m_pmb = merge(m_pmb, d, b);
            6'h12: m_misc = merge(m_misc, d, b);
            6'h20: if (b[0]) m_pmctl = d[7:0];
            6'h24: if (b != 0) m_smbb = (merge(m_smbb, d, b) & 32'h0000fff0) | 32'h1;
            6'h34: if (b[2]) m_smbctl = d[23:16] & 8'h0f;
            default: ;
        endcase
    endtask

    // drives one write cycle; returns at the negedge after the commit edge
    task automatic wr(input logic [5:0] i, input logic [3:0] b, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = i; cfg_be = b; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0;
        model_write(i, b, d);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    function automatic logic [31:0] exp_read(input logic [5:0] i);
        case (i)
            6'h01: return {16'h0, m_cmd};
            6'h10: return m_pmb;
            6'h12: return m_misc;
            6'h20: return {24'h0, m_pmctl};
            6'h24: return m_smbb;
            6'h34: return {8'h0, m_smbctl, 16'h0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic rd_chk(input string req, input logic [5:0] i);
        cfg_idx = i;
        #1;
        chk(req, cfg_rdata, exp_read(i));
    endtask

    task automatic sweep(input string req, input int lo, input int hi);
        int pb, sb;
        logic ep, es;
        pb = int'(m_pmb & 32'h0000ffc0);
        sb = int'(m_smbb & 32'h0000fff0);
        for (int a = lo; a <= hi; a++) begin
            io_addr = a[15:0];
            #1;
            ep = m_pmctl[0] && a >= pb && a < pb + 128;
            es = m_smbctl[0] && a >= sb && a < sb + 16;
            chk({req, " pm_hit"}, {31'h0, pm_hit}, {31'h0, ep});
            chk({req, " smb_hit"}, {31'h0, smb_hit}, {31'h0, es});
            if (ep) chk({req, " pm_offset"}, {25'h0, pm_offset}, 32'((a - pb) & 127));
            if (es) chk({req, " smb_offset"}, {28'h0, smb_offset}, 32'((a - sb) & 15));
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 cmd", 6'h01);
        rd_chk("R1 misc", 6'h12);
        rd_chk("R1 smbbase", 6'h24);
        rd_chk("R1 smbctl", 6'h34);
        rd_chk("R1 pmbase", 6'h10);
        rd_chk("R1 pmctl", 6'h20);
        sweep("R1", 0, 40);

        // R2 lane merge
        wr(6'h10, 4'b0001, 32'haaaa_aa55); rd_chk("R2 pmbase lane0", 6'h10);
        wr(6'h10, 4'b0110, 32'h12ab_cd99); rd_chk("R2 pmbase lanes12", 6'h10);
        wr(6'h12, 4'b1100, 32'hdead_beef); rd_chk("R2 misc upper", 6'h12);
        wr(6'h01, 4'b1111, 32'h1234_0507); rd_chk("R2 cmd", 6'h01);
        wr(6'h20, 4'b1110, 32'hffff_ff00); rd_chk("R2 pmctl lane0 only", 6'h20);

        // R3 smb base masking
        wr(6'h24, 4'b1111, 32'hffff_ffff); rd_chk("R3 full", 6'h24);
        wr(6'h24, 4'b0001, 32'h0000_0000); rd_chk("R3 lane0", 6'h24);
        wr(6'h24, 4'b0010, 32'h0000_3c00); rd_chk("R3 lane1", 6'h24);
        wr(6'h24, 4'b0000, 32'h0000_0000); rd_chk("R3 no lanes", 6'h24);

        // R4 nibble-limited enable byte
        wr(6'h34, 4'b0100, 32'h00ff_0000); rd_chk("R4 keep nibble", 6'h34);
        wr(6'h34, 4'b1011, 32'hffff_ffff); rd_chk("R4 other lanes", 6'h34);
        wr(6'h34, 4'b0100, 32'h0000_0000); rd_chk("R4 clear", 6'h34);

        // R8 unimplemented indices
        wr(6'h05, 4'b1111, 32'hffff_ffff); rd_chk("R8 idx05", 6'h05);
        rd_chk("R8 idx00", 6'h00);
        rd_chk("R8 pmbase untouched", 6'h10);
        rd_chk("R8 smbbase untouched", 6'h24);

        // R5 power-management window
        wr(6'h10, 4'b1111, 32'h0000_1234);
        wr(6'h20, 4'b0001, 32'h0000_0001);
        settle();
        sweep("R5 base1200", 32'h11f0, 32'h1290);
        wr(6'h10, 4'b0011, 32'h0000_ff80);
        settle();
        sweep("R5 top", 32'hff60, 32'hffff);
        wr(6'h20, 4'b0001, 32'h0000_00fe);
        settle();
        sweep("R5 disabled", 32'hff60, 32'hffff);

        // R6 SMBus window
        wr(6'h24, 4'b1111, 32'h0000_2345);
        wr(6'h34, 4'b0100, 32'h00f1_0000);
        settle();
        sweep("R6 base2340", 32'h2330, 32'h2360);
        wr(6'h34, 4'b0100, 32'h000e_0000);
        settle();
        sweep("R6 disabled", 32'h2330, 32'h2360);

        // R7 decode lags the commit by one edge
        wr(6'h10, 4'b1111, 32'h0000_4000);
        settle();
        io_addr = 16'h4010;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'h20; cfg_be = 4'b0001; cfg_wdata = 32'h1;
        #1; chk("R7 before commit", {31'h0, pm_hit}, 32'h0);
        @(negedge clk);
        cfg_wr = 1'b0; cfg_be = '0; model_write(6'h20, 4'b0001, 32'h1);
        #1; chk("R7 after commit edge", {31'h0, pm_hit}, 32'h0);
        cfg_idx = 6'h20; #1; chk("R7 readback immediate", cfg_rdata, 32'h1);
        @(negedge clk);
        #1; chk("R7 after next edge", {31'h0, pm_hit}, 32'h1);
        chk("R7 offset", {25'h0, pm_offset}, 32'h10);

        // R9 back-to-back writes: last one wins
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'h10; cfg_be = 4'b1111; cfg_wdata = 32'h0000_5000;
        @(negedge clk);
        model_write(6'h10, 4'b1111, 32'h0000_5000);
        cfg_wdata = 32'h0000_6040;
        @(negedge clk);
        model_write(6'h10, 4'b1111, 32'h0000_6040);
        cfg_wr = 1'b0; cfg_be = '0;
        settle();
        sweep("R9 last write", 32'h6030, 32'h60d0);
        sweep("R9 earlier base", 32'h5000, 32'h5010);

        // R5 R6 overlapping windows
        wr(6'h10, 4'b1111, 32'h0000_1000);
        wr(6'h24, 4'b1111, 32'h0000_1040);
        wr(6'h34, 4'b0100, 32'h0001_0000);
        settle();
        sweep("R5 R6 overlap", 32'h0ff8, 32'h1088);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule